// File: doc/BRIEF.md
# Receive Byte Ring Buffer

This block sits between a bit-level radio receiver and a host controller. Each time the receiver finishes a byte it pulses a valid flag with the byte and an error flag. Good bytes go into a 16-slot circular store. The host takes them out one at a time with a read strobe. A fill counter shows the host how many unread bytes are waiting. A one-cycle interrupt fires when the counter climbs to a level the host selects.

Bytes that arrive with the error flag set are never stored. Each one raises a separate error pulse, which tells the surrounding logic to return to its start-up state. If the host falls behind, the store does not stall the receiver. The newest byte replaces the oldest one, and the read side moves forward so that the host always gets the oldest byte still held. A configuration-write pulse from the register block empties the store at once.

Top module: `rxq_ring`

## Requirements
- R1: After reset, `fill_cnt` is 0, `rd_data` is 0x00 and both `thr_irq` and `err_irq` are low.
- R2: Stored bytes come out in arrival order. A byte read with `rd_strobe` in cycle k appears on `rd_data` after the clock edge that ends cycle k, and it holds there until the next read or clear.
- R3: The store holds at most 16 bytes, and `fill_cnt` never goes above 16. A byte that arrives with no read while 16 bytes are held overwrites the oldest slot. Later reads then return the oldest surviving byte, and the count stays at 16.
- R4: `thr_irq` pulses for one cycle, registered, when a stored byte raises the count to the selected level. That level is 1, 4, 8 or 12 for `thr_sel` values 0, 1, 2 and 3. The pulse never fires on a decrement, and it never fires while the count is unchanged.
- R5: `fill_cnt` rises by one for each stored byte. It falls by one for each read taken while the store is not empty. The new value is visible after the clock edge.
- R6: A byte presented with `rx_err` high is not stored. The count is not changed by it, and that byte never comes out on `rd_data`.
- R7: An errored byte (`rx_valid` and `rx_err` both high) produces a one-cycle `err_irq` pulse after the next clock edge.
- R8: A read while the store is empty returns 0x00, and `fill_cnt` stays at 0.
- R9: A `cfg_wr` pulse empties the store, sets `fill_cnt` to 0, clears `rd_data` to 0x00 and suppresses both interrupts. It takes priority over a receive or a read in the same cycle.
- R10: A receive and a read in the same cycle, with the store not empty, return the oldest byte and leave `fill_cnt` unchanged. No `thr_irq` pulse fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte | input | 8 | Byte from the bit-level receiver |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` is complete |
| rx_err | input | 1 | The presented byte carries a bit error |
| rd_strobe | input | 1 | Host read request, one byte per cycle |
| thr_sel | input | 2 | Interrupt fill-level select |
| cfg_wr | input | 1 | Configuration write pulse; clears the store |
| rd_data | output | 8 | Last byte read |
| fill_cnt | output | 5 | Number of unread bytes held |
| thr_irq | output | 1 | Fill-level interrupt pulse |
| err_irq | output | 1 | Bit-error interrupt pulse |

## Verification
The bench pushes twenty bytes without reading. This catches a design that blocks on a full store instead of overwriting: it would return the first bytes instead of bytes five through twenty, or its counter would run past 16. The bench reads with and without a receive in the same cycle, and it reads from an empty store. A count that moves during a matched receive and read would show up there, as would a stray threshold pulse or stale data returned on an empty read.

The bench presents errored bytes in the middle of a stream, which exposes a design that stores them or shifts the count. It also fires a configuration write together with a receive and a read. A design that lets the receive win leaves a count of one, and one that lets the read win leaves old data on `rd_data`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Fill level that arms the threshold interrupt for a given select value.
  function automatic int unsigned thr_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return (3 * depth) / 4;
    endcase
  endfunction

  // Circular pointer advance for any depth.
  function automatic int unsigned ptr_inc(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl import rxq_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          push_req,
  input  logic          rd_req,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] fill,
  output logic [CW-1:0] fill_nxt,
  output logic          evt_push,
  output logic          evt_pop,
  output logic          evt_over,
  output logic          evt_up,
  output logic          evt_empty_rd
);

  assign evt_push     = push_req && !cfg_wr;
  assign evt_pop      = rd_req && !cfg_wr && (fill != '0);
  assign evt_empty_rd = rd_req && !cfg_wr && (fill == '0);
  assign evt_over     = evt_push && !evt_pop && (fill == CW'(DEPTH));
  assign evt_up       = evt_push && !evt_pop && !evt_over;

  always_comb begin
    fill_nxt = fill;
    if (cfg_wr)                   fill_nxt = '0;
    else if (evt_up)              fill_nxt = fill + 1'b1;
    else if (evt_pop && !evt_push) fill_nxt = fill - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      fill <= fill_nxt;
      if (cfg_wr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (evt_push)            wr_ptr <= AW'(ptr_inc(wr_ptr, DEPTH));
        if (evt_pop || evt_over) rd_ptr <= AW'(ptr_inc(rd_ptr, DEPTH));
      end
    end
  end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic          re_empty,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(g))) slot[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rdata <= '0;
    else if (clr || re_empty) rdata <= '0;
    else if (re)            rdata <= slot[raddr];
  end

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq import rxq_pkg::*; #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          evt_up,
  input  logic [CW-1:0] fill_nxt,
  input  logic [1:0]    thr_sel,
  input  logic          bad_byte,
  output logic          thr_irq,
  output logic          err_irq
);

  logic [CW-1:0] level;
  assign level = CW'(thr_level(thr_sel, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_irq <= 1'b0;
      err_irq <= 1'b0;
    end else begin
      thr_irq <= !cfg_wr && evt_up && (fill_nxt == level);
      err_irq <= !cfg_wr && bad_byte;
    end
  end

endmodule

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  rx_byte,
  input  logic          rx_valid,
  input  logic          rx_err,
  input  logic          rd_strobe,
  input  logic [1:0]    thr_sel,
  input  logic          cfg_wr,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] fill_cnt,
  output logic          thr_irq,
  output logic          err_irq
);

  logic          good_byte, bad_byte;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill_nxt;
  logic          evt_push, evt_pop, evt_over, evt_up, evt_empty_rd;

  assign good_byte = rx_valid && !rx_err;
  assign bad_byte  = rx_valid && rx_err;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .push_req(good_byte), .rd_req(rd_strobe),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .fill(fill_cnt), .fill_nxt(fill_nxt),
    .evt_push(evt_push), .evt_pop(evt_pop), .evt_over(evt_over), .evt_up(evt_up),
    .evt_empty_rd(evt_empty_rd)
  );

  rxq_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .we(evt_push), .waddr(wr_ptr), .wdata(rx_byte),
    .re(evt_pop), .re_empty(evt_empty_rd), .raddr(rd_ptr), .rdata(rd_data)
  );

  rxq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .evt_up(evt_up), .fill_nxt(fill_nxt),
    .thr_sel(thr_sel), .bad_byte(bad_byte), .thr_irq(thr_irq), .err_irq(err_irq)
  );

endmodule

// File: rtl/rxq_ring_chk.sv
module rxq_ring_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_err,
  input logic          rd_strobe,
  input logic          cfg_wr,
  input logic [W-1:0]  rd_data,
  input logic [CW-1:0] fill_cnt,
  input logic          thr_irq,
  input logic          err_irq,
  input logic          evt_push,
  input logic          evt_pop,
  input logic          evt_over
);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH));

  a_r3_over_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    evt_over |=> fill_cnt == CW'(DEPTH));

  a_r4_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    thr_irq |-> (fill_cnt == $past(fill_cnt) + 1'b1) && $past(evt_push));

  a_r5_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pop && !evt_push && !cfg_wr) |=> fill_cnt == $past(fill_cnt) - 1'b1);

  a_r6_err_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_err && !rd_strobe && !cfg_wr) |=> $stable(fill_cnt));

  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_err && !cfg_wr) |=> err_irq);

  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && fill_cnt == '0 && !cfg_wr) |=> (rd_data == '0) && (fill_cnt <= 1));

  a_r9_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (fill_cnt == '0) && (rd_data == '0) && !thr_irq && !err_irq);

  a_r10_matched: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_push && evt_pop) |=> $stable(fill_cnt) && !thr_irq);

endmodule

bind rxq_ring rxq_ring_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_err(rx_err), .rd_strobe(rd_strobe),
  .cfg_wr(cfg_wr), .rd_data(rd_data), .fill_cnt(fill_cnt), .thr_irq(thr_irq),
  .err_irq(err_irq), .evt_push(evt_push), .evt_pop(evt_pop), .evt_over(evt_over)
);

// File: tb/test_rxq_ring.sv
`timescale 1ns/1ps
module test_rxq_ring;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_valid = 1'b0, rx_err = 1'b0, rd_strobe = 1'b0, cfg_wr = 1'b0;
  logic [1:0] thr_sel = 2'd0;
  logic [7:0] rd_data;
  logic [4:0] fill_cnt;
  logic       thr_irq, err_irq;

  int checks = 0, errors = 0;
  logic [7:0] model_q [$];
  logic [7:0] exp_rd [$];
  string      exp_tag [$];
  logic       rd_seen = 1'b0;

  always #2 clk = ~clk;

  rxq_ring i_rxq_ring (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_err(rx_err),
    .rd_strobe(rd_strobe), .thr_sel(thr_sel), .cfg_wr(cfg_wr), .rd_data(rd_data),
    .fill_cnt(fill_cnt), .thr_irq(thr_irq), .err_irq(err_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int lvl(input logic [1:0] s);
    int t [4] = '{1, 4, 8, 12};
    return t[s];
  endfunction

  // Monitor: a read taken at a posedge is compared at the following negedge.
  always @(posedge clk) rd_seen <= rst_n && rd_strobe;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_rd.size() == 0) chk(1'b0, "R2 unexpected read", rd_data, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_rd.pop_front();
        t = exp_tag.pop_front();
        chk(rd_data === e, t, rd_data, e);
      end
    end
  end

  // Driver: one cycle of stimulus, model update, then count/interrupt checks.
  task automatic step(input bit v, input bit e, input logic [7:0] b, input bit rd, input bit cfg,
                      input string rtag);
    int old;
    bit exp_thr;
    old = model_q.size();
    exp_thr = 1'b0;
    rx_valid = v; rx_err = e; rx_byte = b; rd_strobe = rd; cfg_wr = cfg;
    if (cfg) begin
      model_q.delete();
      if (rd) begin exp_rd.push_back(8'h00); exp_tag.push_back("R9"); end
    end else begin
      if (rd) begin
        if (old > 0) exp_rd.push_back(model_q.pop_front());
        else exp_rd.push_back(8'h00);
        exp_tag.push_back(rtag);
      end
      if (v && !e) begin
        if (model_q.size() == DEPTH) void'(model_q.pop_front());
        model_q.push_back(b);
        exp_thr = (model_q.size() > old) && (model_q.size() == lvl(thr_sel));
      end
    end
    @(negedge clk);
    rx_valid = 0; rx_err = 0; rd_strobe = 0; cfg_wr = 0;
    chk(fill_cnt == 5'(model_q.size()), "R5 fill count", fill_cnt, model_q.size());
    chk(thr_irq == exp_thr, "R4 threshold pulse", thr_irq, exp_thr);
    chk(err_irq == (v && e && !cfg), "R7 error pulse", err_irq, v && e && !cfg);
  endtask

  task automatic push(input logic [7:0] b); step(1, 0, b, 0, 0, "R2"); endtask
  task automatic pull(input string t);     step(0, 0, 8'h00, 1, 0, t); endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fill_cnt == 0 && rd_data == 0 && !thr_irq && !err_irq, "R1 reset state",
        {fill_cnt, rd_data, thr_irq, err_irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Threshold at 4, in-order reads
    thr_sel = 2'd1;
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
    pull("R2"); pull("R2");

    // Errored byte in the middle of a stream
    step(1, 1, 8'hEE, 0, 0, "R6");
    chk(fill_cnt == 3, "R6 count after errored byte", fill_cnt, 3);
    push(8'hB0);
    pull("R6"); pull("R6"); pull("R6"); pull("R6");

    // Empty reads
    pull("R8"); pull("R8");
    chk(fill_cnt == 0, "R8 count stays zero", fill_cnt, 0);

    // Overflow with threshold at 12
    thr_sel = 2'd3;
    for (int i = 0; i < 20; i++) push(8'h10 + 8'(i));
    chk(fill_cnt == 16, "R3 saturated count", fill_cnt, 16);
    step(1, 0, 8'h50, 1, 0, "R3");
    for (int i = 0; i < 16; i++) pull("R3");
    pull("R8");

    // Matched receive and read
    thr_sel = 2'd0;
    push(8'h61); push(8'h62);
    step(1, 0, 8'h63, 1, 0, "R10");
    chk(fill_cnt == 2, "R10 count unchanged", fill_cnt, 2);
    pull("R10"); pull("R10");

    // Configuration write beats receive and read
    push(8'h71); push(8'h72); push(8'h73);
    step(1, 0, 8'h74, 1, 1, "R9");
    chk(fill_cnt == 0 && rd_data == 0, "R9 cleared", {fill_cnt, rd_data}, 0);
    pull("R9");

    // Threshold at 8
    thr_sel = 2'd2;
    for (int i = 0; i < 9; i++) push(8'h80 + 8'(i));
    for (int i = 0; i < 9; i++) pull("R2");

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule